// File: doc/BRIEF.md
# Microsecond Slot Wait-State Generator

This block divides a 16 MHz master clock into a 4 MHz CPU clock and a repeating one-microsecond slot made of four CPU T-states. In every slot a video memory fetch takes a fixed position, and a CPU bus access may proceed only in one fixed T-state phase. The block watches the CPU's active-low memory-request, I/O-request and opcode-fetch strobes. It drives a READY level into the CPU's active-low WAIT input, which holds any access that would collide with the video side.

The CPU samples WAIT on the falling edge of its clock in T2. As a result, every bus cycle transfers its data in the same phase of a slot. The time from one opcode fetch to the next always comes out as a whole number of microseconds, which gives an effective CPU rate of about 3.3 MHz. The same slot counter also drives a 64 µs line counter and a frame counter of 312 lines, which is 19968 µs.

Top module: `usec_wait_gen`

## Requirements
- R1: While the synchronous active-high rst is high, slot_phase is 0, cpu_clk and ready are high, vid_fetch and frame_tick are low, and us_in_line and line_idx are 0. The first master clock edge after release enters the second master clock of T-state 0.
- R2: cpu_clk is the master clock divided by four. It is high during the first two master clocks of each T-state and low during the last two. slot_phase gives the T-state index 0, 1, 2, 3 and then wraps, so one slot is 16 master clocks.
- R3: vid_fetch is a one-master-clock pulse in the second master clock of T-state 0 of every slot. It is present whether or not the CPU drives any strobe.
- R4: On each master clock edge, ready is driven low if any of mreq_n, iorq_n or m1_n was low at that edge and the T-state being entered is not phase 1. Otherwise ready is driven high.
- R5: A bus cycle that samples ready in its second T-state and in any wait states can only continue out of a phase-1 T-state. Its data-transfer T-state is therefore always phase 2 and never phase 0, where the video fetch sits.
- R6: The time from one opcode fetch's accepted sample to the next is a whole number of slots, as follows:
  - a bare 4-T fetch takes 1 µs;
  - a fetch followed by a 3-T read takes 2 µs;
  - a 6-T fetch takes 2 µs;
  - a fetch followed by two reads takes 3 µs;
  - a fetch, a read and a 4-T I/O cycle take 3 µs;
  - a 5-T fetch followed by two 3-T writes takes 4 µs;
  - a fetch followed by 3 idle T-states takes 2 µs.
- R7: A conditional relative jump takes 2 µs when the condition fails (fetch plus read). It takes 3 µs when the condition holds (fetch, read and 5 internal T-states).
- R8: us_in_line counts slots from 0 to LINE_US-1 (default 64). It advances on the edge where a new slot begins and wraps to 0.
- R9: line_idx counts lines from 0 to FRAME_LINES-1 (default 312, a 19968 µs frame). frame_tick is a one-master-clock pulse on the edge where both counters wrap to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| mreq_n | input | 1 | CPU memory request, active low |
| iorq_n | input | 1 | CPU I/O request, active low |
| m1_n | input | 1 | CPU opcode-fetch cycle marker, active low |
| cpu_clk | output | 1 | Derived 4 MHz CPU clock |
| ready | output | 1 | To the CPU WAIT input; low holds the bus cycle |
| vid_fetch | output | 1 | One-clock video fetch strobe per slot |
| slot_phase | output | 2 | T-state index within the current slot |
| us_in_line | output | $clog2(LINE_US) | Slot index within the line |
| line_idx | output | $clog2(FRAME_LINES) | Line index within the frame |
| frame_tick | output | 1 | Pulse at the start of each frame |

## Verification
The assertions watch the local rules on every cycle. These are:
- the shape of the CPU clock edge;
- the single-clock width and slot position of the video strobe;
- READY falling whenever a strobe meets a phase other than 1, and rising when the bus is idle;
- line counters that stay still between slots and sit at zero on a frame pulse.

Only the bench's scripted instruction sequences can show what these rules add up to. Data transfers land in phase 2. Fetch-to-fetch spacing comes out as whole microseconds for fetches, reads, writes, I/O cycles, internal T-states and a misaligned start. Both branches of a conditional jump reach their expected totals.

// File: rtl/usw_pkg.sv
package usw_pkg;

    localparam int TPH_W = 2;
    localparam int SUB_W = 2;

    typedef logic [TPH_W-1:0] tphase_t;

    typedef struct packed {
        tphase_t          tph;
        logic [SUB_W-1:0] sub;
    } slot_pos_t;

    typedef struct packed {
        logic m1;
        logic mreq;
        logic iorq;
    } bus_req_t;

    function automatic slot_pos_t pos_advance(slot_pos_t p);
        logic [TPH_W+SUB_W-1:0] v;
        v = p;
        v = v + 1'b1;
        return slot_pos_t'(v);
    endfunction

    function automatic logic pos_is_last(slot_pos_t p);
        return &p;
    endfunction

    function automatic logic req_any(bus_req_t r);
        return |r;
    endfunction

endpackage

// File: rtl/usw_slot_timer.sv
module usw_slot_timer
    import usw_pkg::*;
#(
    parameter int VID_TPH = 0,
    parameter int VID_SUB = 1
) (
    input  logic    clk,
    input  logic    rst,
    output tphase_t tph,
    output tphase_t tph_nxt,
    output logic    cpu_clk,
    output logic    vid_fetch,
    output logic    slot_last
);

    localparam slot_pos_t VID_POS = slot_pos_t'({tphase_t'(VID_TPH), 2'(VID_SUB)});

    slot_pos_t pos;
    slot_pos_t pos_nxt;

    always_comb begin
        pos_nxt   = pos_advance(pos);
        slot_last = pos_is_last(pos);
        tph       = pos.tph;
        tph_nxt   = pos_nxt.tph;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos       <= '0;
            cpu_clk   <= 1'b1;
            vid_fetch <= 1'b0;
        end else begin
            pos       <= pos_nxt;
            cpu_clk   <= ~pos_nxt.sub[SUB_W-1];
            vid_fetch <= (pos_nxt == VID_POS);
        end
    end

    // R2
    cpu_clk_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_clk) |-> (pos.sub == '0));

    // R3
    vid_width_chk: assert property (@(posedge clk) disable iff (rst)
        vid_fetch |=> !vid_fetch);

    // R3
    vid_place_chk: assert property (@(posedge clk) disable iff (rst)
        vid_fetch |-> (pos.tph == tphase_t'(VID_TPH)));

endmodule

// File: rtl/usw_ready_gen.sv
module usw_ready_gen
    import usw_pkg::*;
#(
    parameter int GO_TPH = 1
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    input  tphase_t  tph,
    input  tphase_t  tph_nxt,
    output logic     ready
);

    localparam tphase_t GO = tphase_t'(GO_TPH);

    logic req_on;
    assign req_on = req_any(req);

    always_ff @(posedge clk) begin
        if (rst) ready <= 1'b1;
        else     ready <= !(req_on && (tph_nxt != GO));
    end

    // R4
    hold_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req_on) && (tph != GO)) |-> !ready);

    // R4
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(req_on)) |-> ready);

    // R5
    grant_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req_on) && ready) |-> (tph == GO));

endmodule

// File: rtl/usw_raster.sv
module usw_raster #(
    parameter int  LINE_US     = 64,
    parameter int  FRAME_LINES = 312,
    localparam int US_W        = $clog2(LINE_US),
    localparam int LN_W        = $clog2(FRAME_LINES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            slot_last,
    output logic [US_W-1:0] us,
    output logic [LN_W-1:0] line,
    output logic            frame_tick
);

    logic us_wrap;
    logic line_wrap;

    always_comb begin
        us_wrap   = slot_last && (us == US_W'(LINE_US - 1));
        line_wrap = us_wrap && (line == LN_W'(FRAME_LINES - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            us         <= '0;
            line       <= '0;
            frame_tick <= 1'b0;
        end else begin
            if (slot_last) us <= us_wrap ? '0 : us + US_W'(1);
            if (us_wrap)   line <= line_wrap ? '0 : line + LN_W'(1);
            frame_tick <= line_wrap;
        end
    end

    // R8
    us_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !slot_last |=> $stable(us));

    // R9
    frame_origin_chk: assert property (@(posedge clk) disable iff (rst)
        frame_tick |-> ((us == '0) && (line == '0)));

    // R9
    line_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(line) < FRAME_LINES);

endmodule

// File: rtl/usec_wait_gen.sv
module usec_wait_gen
    import usw_pkg::*;
#(
    parameter int  GO_TPH      = 1,
    parameter int  VID_TPH     = 0,
    parameter int  VID_SUB     = 1,
    parameter int  LINE_US     = 64,
    parameter int  FRAME_LINES = 312,
    localparam int US_W        = $clog2(LINE_US),
    localparam int LN_W        = $clog2(FRAME_LINES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            mreq_n,
    input  logic            iorq_n,
    input  logic            m1_n,
    output logic            cpu_clk,
    output logic            ready,
    output logic            vid_fetch,
    output logic [1:0]      slot_phase,
    output logic [US_W-1:0] us_in_line,
    output logic [LN_W-1:0] line_idx,
    output logic            frame_tick
);

    bus_req_t req;
    tphase_t  tph;
    tphase_t  tph_nxt;
    logic     slot_last;

    assign req = '{m1: ~m1_n, mreq: ~mreq_n, iorq: ~iorq_n};
    assign slot_phase = tph;

    usw_slot_timer #(
        .VID_TPH(VID_TPH),
        .VID_SUB(VID_SUB)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .tph       (tph),
        .tph_nxt   (tph_nxt),
        .cpu_clk   (cpu_clk),
        .vid_fetch (vid_fetch),
        .slot_last (slot_last)
    );

    usw_ready_gen #(
        .GO_TPH(GO_TPH)
    ) u_ready (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .tph     (tph),
        .tph_nxt (tph_nxt),
        .ready   (ready)
    );

    usw_raster #(
        .LINE_US     (LINE_US),
        .FRAME_LINES (FRAME_LINES)
    ) u_raster (
        .clk        (clk),
        .rst        (rst),
        .slot_last  (slot_last),
        .us         (us_in_line),
        .line       (line_idx),
        .frame_tick (frame_tick)
    );

endmodule

// File: tb/tb_usec_wait_gen.sv
module tb_usec_wait_gen;

    localparam int LINES = 3;
    localparam int SLOT  = 16;
    localparam int LINEC = 16 * 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mreq_n = 1'b1;
    logic       iorq_n = 1'b1;
    logic       m1_n = 1'b1;
    logic       cpu_clk;
    logic       ready;
    logic       vid_fetch;
    logic [1:0] slot_phase;
    logic [5:0] us_in_line;
    logic [1:0] line_idx;
    logic       frame_tick;

    int checks = 0;
    int fails  = 0;
    int mc     = 0;
    bit done   = 1'b0;

    int    exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    usec_wait_gen #(.FRAME_LINES(LINES)) dut (
        .clk(clk), .rst(rst), .mreq_n(mreq_n), .iorq_n(iorq_n), .m1_n(m1_n),
        .cpu_clk(cpu_clk), .ready(ready), .vid_fetch(vid_fetch),
        .slot_phase(slot_phase), .us_in_line(us_in_line), .line_idx(line_idx),
        .frame_tick(frame_tick)
    );

    always @(posedge clk) begin
        if (rst) mc <= 0;
        else     mc <= mc + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (master clock %0d)", req, act, exp, mc);
        end
    endtask

    // Monitor: per-clock port rules and fetch-to-fetch scoreboard
    int m1_run  = 0;
    int last_m1 = -1;
    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            int  exp_us;
            bit  req_on;
            req_on = !mreq_n || !iorq_n || !m1_n;
            chk(cpu_clk == ((mc % 4) < 2), "R2 cpu_clk", cpu_clk, ((mc % 4) < 2));
            chk(int'(slot_phase) == (mc / 4) % 4, "R2 slot_phase", slot_phase, (mc / 4) % 4);
            chk(vid_fetch == ((mc % SLOT) == 1), "R3 vid_fetch", vid_fetch, ((mc % SLOT) == 1));
            chk(ready == !(req_on && ((mc / 4) % 4) != 1), "R4 ready", ready,
                !(req_on && ((mc / 4) % 4) != 1));
            chk(int'(us_in_line) == (mc / SLOT) % 64, "R8 us_in_line", us_in_line, (mc / SLOT) % 64);
            chk(int'(line_idx) == (mc / LINEC) % LINES, "R9 line_idx", line_idx, (mc / LINEC) % LINES);
            chk(frame_tick == (mc > 0 && (mc % (LINEC * LINES)) == 0), "R9 frame_tick", frame_tick,
                (mc > 0 && (mc % (LINEC * LINES)) == 0));
            if (!m1_n) m1_run++;
            else       m1_run = 0;
            if ((mc % 4) == 2 && !m1_n && ready && m1_run >= 6) begin
                if (last_m1 >= 0) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R6 scoreboard underflow", mc - last_m1, -1);
                    end else begin
                        string t;
                        exp_us = exp_q.pop_front();
                        t = tag_q.pop_front();
                        chk((mc - last_m1) == exp_us * SLOT, t, mc - last_m1, exp_us * SLOT);
                    end
                end
                last_m1 = mc;
            end
        end
    end

    // Driver
    task automatic tstate(input bit a_m1, input bit a_mreq, input bit a_iorq, output logic r);
        m1_n   = !a_m1;
        mreq_n = !a_mreq;
        iorq_n = !a_iorq;
        @(negedge clk);
        @(negedge clk);
        r = ready;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic bus_cycle(input bit is_m1, input bit is_io, input int base);
        logic r;
        int   ph;
        tstate(is_m1, !is_io, is_io, r);
        tstate(is_m1, !is_io, is_io, r);
        while (!r) tstate(is_m1, !is_io, is_io, r);
        ph = (mc / 4) % 4;
        chk(ph == 2, "R5 data phase", ph, 2);
        repeat (base - 2) tstate(1'b0, !is_io, is_io, r);
    endtask

    task automatic idle(input int n);
        logic r;
        repeat (n) tstate(1'b0, 1'b0, 1'b0, r);
    endtask

    task automatic expect_us(input int us, input string tag);
        exp_q.push_back(us);
        tag_q.push_back(tag);
    endtask

    task automatic fetch(input int base);
        bus_cycle(1'b1, 1'b0, base);
    endtask

    task automatic mem(input int base);
        bus_cycle(1'b0, 1'b0, base);
    endtask

    task automatic print_summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(slot_phase == 2'd0, "R1 slot_phase", slot_phase, 0);
        chk(cpu_clk == 1'b1, "R1 cpu_clk", cpu_clk, 1);
        chk(ready == 1'b1, "R1 ready", ready, 1);
        chk(vid_fetch == 1'b0, "R1 vid_fetch", vid_fetch, 0);
        chk(frame_tick == 1'b0, "R1 frame_tick", frame_tick, 0);
        chk(us_in_line == 6'd0 && line_idx == 2'd0, "R1 counters", us_in_line, 0);
        rst = 1'b0;

        idle(5);                                 // R3: strobe runs with an idle CPU
        expect_us(1, "R6 bare fetch");           fetch(4);
        expect_us(2, "R6 fetch plus read");      fetch(4); mem(3);
        expect_us(2, "R7 jump not taken");       fetch(4); mem(3);
        expect_us(3, "R7 jump taken");           fetch(4); mem(3); idle(5);
        expect_us(2, "R6 six-T fetch");          fetch(6);
        expect_us(3, "R6 fetch two reads");      fetch(4); mem(3); mem(3);
        expect_us(3, "R6 fetch read io");        fetch(4); mem(3); bus_cycle(1'b0, 1'b1, 4);
        expect_us(4, "R6 fetch two writes");     fetch(5); mem(3); mem(3);
        expect_us(2, "R6 fetch with idle gap");  fetch(4); idle(3);
        fetch(4);
        idle(2);

        while (mc < 2 * LINEC * LINES + 40) @(negedge clk);
        chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        print_summary();
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", mc, 0);
            print_summary();
            $finish;
        end
    end

endmodule